// File: doc/BRIEF.md
# Serial Byte-Memory Slave on a Two-Wire Bus

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) in front of a 2048 x 8 byte array that it holds internally as registers. A fast system clock oversamples both bus lines. The block finds START and STOP conditions and decodes the first byte after every START. That byte holds a fixed device type, three high memory address bits and a direction bit. In a write, a word address byte follows, then data bytes that the block stores at consecutive locations. In a read, the block sends bytes from consecutive locations for as long as the master keeps acknowledging.

The block drives the data line only through an output enable, which pulls the line low. It never drives the line high. The eleven-bit memory address is the three slave-byte bits placed above the eight-bit word address byte. A read with no word address starts at the three slave-byte bits placed above the low byte of the internal pointer. A missing acknowledge from the master during a read makes the block go quiet until the next START or STOP.

Top module: `i2c_mem_slave`

## Requirements
- R1: During and after reset, `sda_oe_o` is 0 and the block waits for a START.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. After a STOP, `sda_oe_o` stays 0.
- R3: A first byte after a START with bits 7:4 equal to 4'b1010 is acknowledged: `sda_oe_o` is 1 during the ninth SCL high phase. Bits 3:1 are address bits 10:8. Bit 0 is the direction: 1 means read, 0 means write.
- R4: A first byte whose bits 7:4 are not 4'b1010 gets no acknowledge. Every later byte is also ignored, with `sda_oe_o` held at 0, until the next START.
- R5: In a write, the block acknowledges the word address byte and every data byte. Each data byte goes to address {slave bits 3:1, word byte} and then to the following addresses.
- R6: A read sends bytes MSB first, one bit per SCL pulse. During the SCL high phase, `sda_oe_o` is 1 for a 0 bit and 0 for a 1 bit. A read starts at {slave bits 3:1, low 8 bits of the internal pointer}.
- R7: If the master acknowledges (SDA low in the ninth phase) after a read byte, the next byte follows from the next address.
- R8: If the master does not acknowledge after a read byte, the block releases SDA. It keeps `sda_oe_o` at 0 for any further SCL pulses until a START or STOP.
- R9: The internal pointer advances by one after each byte written or read and wraps from 2047 to 0.
- R10: A repeated START at any point, including inside a byte, restarts decoding of the first byte. An unfinished word address byte leaves the pointer unchanged.
- R11: `sda_oe_o` changes only while the synchronized SCL is low, except on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When 1, pull the data line low |

## Verification
A bus edge reaches the decoder three system clocks after it occurs on the pins: two synchronizer stages plus the previous-level register. A change of the enable caused by an SCL fall therefore appears three to four clocks after the fall. The bench holds each SCL phase for ten clocks. It changes its data bit five clocks into the low phase. It samples `sda_oe_o` two and eight clocks into the high phase, where the value due from the preceding fall is long settled and not yet disturbed by the next one. Expected bits come from a behavioural byte array and pointer in the bench, updated per transaction.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prv_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] sh_q;
    // bus idles high; reset high avoids a false START
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-1:0], line_i[g]};
    end
    assign lvl_o[g] = sh_q[STAGES-1];
    assign prv_o[g] = sh_q[STAGES];
  end
endmodule

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int         ADDR_W      = 11,
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import i2c_mem_pkg::*;

  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [1:0] lvl, prv;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i({scl_i, sda_i}),
    .lvl_o (lvl),
    .prv_o (prv)
  );

  assign scl_s     = lvl[1];
  assign sda_s     = lvl[0];
  assign scl_p     = prv[1];
  assign sda_p     = prv[0];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  slv_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        rx_q, tx_q;
  logic [HI_W-1:0]   hi_q;
  logic              rw_q, ack_q, nack_q;
  logic [ADDR_W-1:0] ptr_q, rd_addr;
  logic [7:0]        rd_data;
  logic              mem_we;
  logic              byte_done;

  assign byte_done = scl_fall & (cnt_q == 4'd8);
  assign mem_we    = (state_q == ST_WDATA) & byte_done;
  // first read byte takes high bits from the slave byte
  assign rd_addr   = (state_q == ST_DEV_ACK) ? {hi_q, ptr_q[7:0]} : ptr_q;

  i2c_byte_ram #(.AW(ADDR_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(ptr_q),
    .wdata_i(rx_q),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      hi_q    <= '0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      nack_q  <= 1'b1;
      ptr_q   <= '0;
    end else if (start_det) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != 4'd8) begin
            rx_q  <= {rx_q[6:0], sda_s};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            if (state_q == ST_DEV) begin
              if (rx_q[7:4] == DEV_ID) begin
                ack_q   <= 1'b1;
                hi_q    <= rx_q[3:1];
                rw_q    <= rx_q[0];
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADDR) begin
              ack_q   <= 1'b1;
              ptr_q   <= {hi_q, rx_q};
              state_q <= ST_WADDR_ACK;
            end else begin
              ack_q   <= 1'b1;
              ptr_q   <= ptr_q + ONE;
              state_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data;
              ptr_q   <= rd_addr + ONE;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            ack_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              cnt_q   <= '0;
              state_q <= ST_RACK;
            end else begin
              cnt_q <= cnt_q + 4'd1;
              tx_q  <= {tx_q[6:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_q <= sda_s;
          else if (scl_fall) begin
            if (!nack_q) begin
              tx_q    <= rd_data;
              ptr_q   <= ptr_q + ONE;
              state_q <= ST_RDATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = ack_q | ((state_q == ST_RDATA) & ~tx_q[7]);
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input slv_state_e state_q,
  input logic       mem_we,
  input logic       sda_oe_o
);
  a_r2_start_decodes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_DEV));

  a_r2_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && !start_det) |=> (state_q == ST_IDLE));

  a_r8_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  a_r5_write_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> sda_oe_o);

  a_r11_oe_quiet_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .state_q  (state_q),
  .mem_we   (mem_we),
  .sda_oe_o (sda_oe_o)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0]  ref_mem [0:2047];
  logic [10:0] ref_ptr = '0;
  logic [7:0]  wq [$];

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_mem_slave dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: sda_oe_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic mb, input logic exp_oe, input string tag);
    sda_m = mb;
    wt(5);
    scl_m = 1'b1;
    wt(2);
    chk(sda_oe, exp_oe, tag);
    wt(6);
    chk(sda_oe, exp_oe, {tag, " R11 stable in high phase"});
    wt(2);
    scl_m = 1'b0;
    wt(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(5);
    scl_m = 1'b1; wt(5);
    sda_m = 1'b0; wt(5);
    scl_m = 1'b0; wt(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(5);
    scl_m = 1'b1; wt(5);
    sda_m = 1'b1; wt(5);
    chk(sda_oe, 1'b0, "R2 released after STOP");
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, tag);
    clk_bit(1'b1, exp_ack, {tag, " ack"});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic m_ack, input string tag);
    for (int i = 7; i >= 0; i--) clk_bit(1'b1, ~exp[i], tag);
    clk_bit(~m_ack, 1'b0, {tag, " master ack slot"});
  endtask

  // write queue wq starting at {hi, word}
  task automatic write_txn(input logic [2:0] hi, input logic [7:0] word);
    logic [10:0] a;
    bus_start();
    send_byte({4'b1010, hi, 1'b0}, 1'b1, "R3 slave byte write");
    send_byte(word, 1'b1, "R5 word address");
    a = {hi, word};
    while (wq.size() > 0) begin
      logic [7:0] b;
      b = wq.pop_front();
      send_byte(b, 1'b1, "R5 data byte");
      ref_mem[a] = b;
      a = a + 11'd1;
    end
    ref_ptr = a;
    bus_stop();
  endtask

  task automatic read_bytes(input logic [2:0] hi, input int n, input string tag);
    logic [10:0] a;
    a = {hi, ref_ptr[7:0]};
    send_byte({4'b1010, hi, 1'b1}, 1'b1, "R3 slave byte read");
    for (int k = 0; k < n; k++) begin
      recv_byte(ref_mem[a], (k != n - 1), tag);
      a = a + 11'd1;
    end
    ref_ptr = a;
    // R8: further pulses after NACK must see no drive
    for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, "R8 quiet after NACK");
    bus_stop();
  endtask

  task automatic random_read(input logic [2:0] hi, input logic [7:0] word, input int n, input string tag);
    bus_start();
    send_byte({4'b1010, hi, 1'b0}, 1'b1, "R3 dummy write");
    send_byte(word, 1'b1, "R5 word address");
    ref_ptr = {hi, word};
    bus_start();
    read_bytes(hi, n, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    wt(3);
    chk(sda_oe, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe, 1'b0, "R1 after reset");

    wq = '{8'h77};
    write_txn(3'd5, 8'h13);
    wq = '{8'h11, 8'h22};
    write_txn(3'd3, 8'h45);
    random_read(3'd3, 8'h45, 2, "R6 R7 random read");

    // pointer ends at 0x213; current read with high bits 5 hits 0x513
    wq = '{8'h01, 8'h02, 8'h03};
    write_txn(3'd2, 8'h10);
    bus_start();
    read_bytes(3'd5, 1, "R6 current read high bits");

    // R4: wrong type, then a matching-looking byte without START
    bus_start();
    send_byte(8'b1011_0000, 1'b0, "R4 wrong device type");
    send_byte(8'b1010_0000, 1'b0, "R4 ignored until START");
    send_byte(8'h00, 1'b0, "R4 ignored until START");
    bus_stop();

    // R9 wrap across 2047
    wq = '{8'hA5, 8'h5A, 8'h3C};
    write_txn(3'd7, 8'hFF);
    random_read(3'd7, 8'hFF, 2, "R9 wrap read");

    // R10: repeated START inside word address byte
    bus_start();
    send_byte({4'b1010, 3'd0, 1'b0}, 1'b1, "R10 slave byte");
    clk_bit(1'b1, 1'b0, "R10 partial word");
    clk_bit(1'b0, 1'b0, "R10 partial word");
    clk_bit(1'b1, 1'b0, "R10 partial word");
    bus_start();
    read_bytes(3'd0, 1, "R10 read after repeated START");

    wt(10);
    chk(sda_oe, 1'b0, "R2 idle at end");
    done = 1'b1;
    finish_run();
  end
endmodule